// File: doc/BRIEF.md
# Bit-Serial Integer Cube Root

This block takes an unsigned operand of `OPW` bits, where `OPW` is a multiple of three, and returns its integer cube root. It also returns the remainder, which is the operand minus the cube of the root. It produces one root bit on each clock and uses only shifts, additions, subtractions and one compare. No multiplier is built. The block keeps three values between steps: the partial root, its square and the running remainder. At each step it takes the next three operand bits, most significant first, and decides the next root bit from them.

A caller drives a one-cycle `start_i` pulse together with the operand. It then waits for `done_o`. The root and the remainder stay on the outputs until the next accepted start. To take the root of a fixed-point value, shift the operand so that it carries 3n fractional bits. The root then carries n fractional bits. For a negative value, pass the magnitude and restore the sign outside the block.

Top module: `cbrt_serial`

## Requirements
- R1: While reset is high at a clock edge, the block returns to idle. After that edge `busy_o` and `done_o` are 0 and `root_o` and `rem_o` are zero.
- R2: A clock edge that samples `start_i` high while `busy_o` is low accepts the operand. `busy_o` is 1 after that edge.
- R3: After a computation, `root_o` is the largest value r with r³ ≤ operand. For every operand, root³ ≤ operand < (root+1)³.
- R4: After a computation, `rem_o` equals the operand minus `root_o`³. It is never more than 3·root² + 3·root.
- R5: `done_o` goes high after the (OPW/3 + 1)th rising edge, counting the edge that accepted the start as the first. It stays high for exactly one cycle, and `busy_o` is low while it is high.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running result and its timing belong to the operand that was accepted first.
- R7: While the block is idle and `start_i` is low, `root_o` and `rem_o` keep their values.
- R8: A start given in the same cycle as `done_o` is accepted, so back-to-back roots lose no cycle.
- R9: An operand that carries 3n fractional bits gives a root that carries n fractional bits. For example, 8.0 with three fractional bits (operand 64) gives 2.0 with one fractional bit (root 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; accepted only while idle |
| operand_i | input | OPW | Unsigned radicand, sampled with an accepted start |
| busy_o | output | 1 | High while root bits are being produced |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| root_o | output | OPW/3 | Integer cube root |
| rem_o | output | OPW | Operand minus root cubed |

## Verification
The bound checker tests the following on every cycle:
- The result identity root³ + remainder = captured operand holds whenever `done_o` is high.
- The remainder bound holds whenever `done_o` is high.
- `done_o` is a single pulse, arrives after the expected number of busy cycles, and is never high together with `busy_o`.
- The outputs hold still while the block is idle.

Only the bench scenarios show the rest:
- The cube-root property is met for every 12-bit operand.
- A start pulse in mid-run leaves the result unchanged.
- A start in the done cycle is accepted.
- A reset in mid-run clears the state.

// File: rtl/cbrt_pkg.sv
package cbrt_pkg;

    // Width of a counter that must reach the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Bits of operand consumed on each step.
    localparam int unsigned DIGIT_BITS = 3;

endpackage

// File: rtl/cbrt_ctrl.sv
module cbrt_ctrl
    import cbrt_pkg::*;
#(
    parameter int unsigned STEPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CW = cnt_width(STEPS);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (load_o) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(STEPS - 1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cbrt_step.sv
module cbrt_step
    import cbrt_pkg::*;
#(
    parameter int unsigned OPW = 12,
    parameter int unsigned RTW = OPW / 3
) (
    input  logic [OPW-1:0]          rem_i,
    input  logic [DIGIT_BITS-1:0]   digit_i,
    input  logic [RTW-1:0]          root_i,
    input  logic [2*RTW-1:0]        sq_i,
    output logic [OPW-1:0]          rem_o,
    output logic [RTW-1:0]          root_o,
    output logic [2*RTW-1:0]        sq_o
);
    localparam int unsigned TW  = OPW + DIGIT_BITS;
    localparam int unsigned SQW = 2 * RTW;

    logic [TW-1:0] rem_sh;
    logic [TW-1:0] sq_x;
    logic [TW-1:0] rt_x;
    logic [TW-1:0] sq_term;
    logic [TW-1:0] rt_term;
    logic [TW-1:0] trial;
    logic [TW-1:0] diff;
    logic          take;

    always_comb begin
        rem_sh  = {rem_i, digit_i};
        sq_x    = TW'(sq_i);
        rt_x    = TW'(root_i);
        // 12*r^2 and 6*r+1, built from shifts
        sq_term = (sq_x << 3) + (sq_x << 2);
        rt_term = (rt_x << 2) + (rt_x << 1) + TW'(1);
        trial   = sq_term + rt_term;
        take    = (rem_sh >= trial);
        diff    = rem_sh - trial;
        rem_o   = OPW'(take ? diff : rem_sh);
        root_o  = RTW'({root_i, take});
        // (2r+b)^2 = 4r^2 + b*(4r+1)
        sq_o    = take ? ((sq_i << 2) + (SQW'(root_i) << 2) + SQW'(1))
                       : (sq_i << 2);
    end
endmodule

// File: rtl/cbrt_serial.sv
module cbrt_serial
    import cbrt_pkg::*;
#(
    parameter int unsigned OPW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [OPW-1:0]   operand_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [OPW/3-1:0] root_o,
    output logic [OPW-1:0]   rem_o
);
    localparam int unsigned STEPS = OPW / DIGIT_BITS;
    localparam int unsigned RTW   = STEPS;
    localparam int unsigned SQW   = 2 * RTW;

    logic load, step;

    logic [OPW-1:0] opr_q, rem_q, rem_nx;
    logic [RTW-1:0] root_q, root_nx;
    logic [SQW-1:0] sq_q, sq_nx;

    cbrt_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    cbrt_step #(.OPW(OPW), .RTW(RTW)) u_step (
        .rem_i   (rem_q),
        .digit_i (opr_q[OPW-1 -: DIGIT_BITS]),
        .root_i  (root_q),
        .sq_i    (sq_q),
        .rem_o   (rem_nx),
        .root_o  (root_nx),
        .sq_o    (sq_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opr_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            sq_q   <= '0;
        end else if (load) begin
            opr_q  <= operand_i;
            rem_q  <= '0;
            root_q <= '0;
            sq_q   <= '0;
        end else if (step) begin
            opr_q  <= opr_q << DIGIT_BITS;
            rem_q  <= rem_nx;
            root_q <= root_nx;
            sq_q   <= sq_nx;
        end
    end

    assign root_o = root_q;
    assign rem_o  = rem_q;
endmodule

// File: rtl/cbrt_serial_chk.sv
module cbrt_serial_chk #(
    parameter int unsigned OPW = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [OPW-1:0]   operand_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [OPW/3-1:0] root_o,
    input logic [OPW-1:0]   rem_o
);
    localparam int unsigned K  = OPW / 3;
    localparam int unsigned WW = 2 * OPW + 4;
    localparam int unsigned CW = $clog2(K + 2) + 1;

    logic [OPW-1:0] cap_q;
    logic [CW-1:0]  run_q;
    logic [WW-1:0]  rt_w, cube_w, bound_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            run_q <= '0;
        end else if (start_i && !busy_o) begin
            cap_q <= operand_i;
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        rt_w    = WW'(root_o);
        cube_w  = rt_w * rt_w * rt_w;
        bound_w = WW'(3) * rt_w * rt_w + WW'(3) * rt_w;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && root_o == '0 && rem_o == '0));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_q == CW'(K)));

    a_r4_identity: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cube_w + WW'(rem_o) == WW'(cap_q)));

    a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (WW'(rem_o) <= bound_w));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(root_o) && $stable(rem_o)));
endmodule

bind cbrt_serial cbrt_serial_chk #(.OPW(OPW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .operand_i (operand_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .root_o    (root_o),
    .rem_o     (rem_o)
);

// File: tb/cbrt_serial_tb.sv
module cbrt_serial_tb;
    localparam int OPW      = 12;
    localparam int K        = OPW / 3;
    localparam int CLK_T    = 10;
    localparam int WD_LIMIT = 150000;
    localparam int NV       = 14;

    // operand, expected root, expected remainder
    localparam int VEC_OP  [NV] = '{0, 1, 7, 8, 26, 27, 63, 64, 999, 1000, 3374, 3375, 4095, 2};
    localparam int VEC_RT  [NV] = '{0, 1, 1, 2, 2,  3,  3,  4,  9,   10,   14,   15,   15,   1};
    localparam int VEC_REM [NV] = '{0, 0, 6, 0, 18, 0,  36, 0,  270, 0,    630,  0,    720,  1};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [OPW-1:0]   operand_i = '0;
    logic             busy_o, done_o;
    logic [K-1:0]     root_o;
    logic [OPW-1:0]   rem_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    cbrt_serial #(.OPW(OPW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .operand_i(operand_i),
        .busy_o(busy_o), .done_o(done_o), .root_o(root_o), .rem_o(rem_o)
    );

    always #(CLK_T/2) clk = ~clk;

    function automatic int ref_root(input int x);
        int r = 0;
        while ((r + 1) * (r + 1) * (r + 1) <= x) r++;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Drives one start and waits for done; returns at the negedge where done is seen.
    task automatic run_op(input int op, input bit now, output int lat);
        if (!now) @(negedge clk);
        start_i   = 1'b1;
        operand_i = OPW'(op);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        int lat;
        int r0, m0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 root", int'(root_o), 0);
        check("R1 rem",  int'(rem_o), 0);
        rst = 1'b0;

        // Vector table: R3, R4 (entry 64 doubles as R9 fixed-point case)
        for (int i = 0; i < NV; i++) begin
            run_op(VEC_OP[i], 1'b0, lat);
            check("R3 table root", int'(root_o), VEC_RT[i]);
            check("R4 table rem",  int'(rem_o), VEC_REM[i]);
            check("R5 latency", lat, K + 1);
        end

        // R9: 8.0 with three fractional bits gives 2.0 with one
        run_op(8 << 3, 1'b0, lat);
        check("R9 fixed root", int'(root_o), 2 << 1);

        // R2: busy after accepted start
        @(negedge clk);
        start_i = 1'b1; operand_i = OPW'(100);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy", int'(busy_o), 1);
        check("R5 no early done", int'(done_o), 0);
        while (!done_o) @(negedge clk);
        check("R5 done idle", int'(busy_o), 0);
        @(negedge clk);
        check("R5 single pulse", int'(done_o), 0);

        // R7: outputs hold while idle
        r0 = int'(root_o); m0 = int'(rem_o);
        repeat (4) @(negedge clk);
        check("R7 root hold", int'(root_o), r0);
        check("R7 rem hold",  int'(rem_o), m0);

        // R6: start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; operand_i = OPW'(1728);
        @(negedge clk);
        operand_i = OPW'(5);
        @(negedge clk);
        start_i = 1'b0;
        lat = 2;
        while (!done_o && lat < 40) begin @(negedge clk); lat++; end
        check("R6 root", int'(root_o), 12);
        check("R6 rem",  int'(rem_o), 0);
        check("R6 latency", lat, K + 1);

        // R8: start in the done cycle
        run_op(343, 1'b1, lat);
        check("R8 root", int'(root_o), 7);
        check("R8 latency", lat, K + 1);

        // R1: reset in mid-run
        @(negedge clk);
        start_i = 1'b1; operand_i = OPW'(4000);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid busy", int'(busy_o), 0);
        check("R1 mid root", int'(root_o), 0);
        check("R1 mid rem",  int'(rem_o), 0);
        repeat (K + 2) @(negedge clk);
        check("R1 no done", int'(done_o), 0);

        // Exhaustive sweep: R3, R4
        for (int x = 0; x < (1 << OPW); x++) begin
            int er;
            er = ref_root(x);
            run_op(x, 1'b1, lat);
            if (int'(root_o) != er || int'(rem_o) != x - er * er * er) begin
                check("R3 sweep root", int'(root_o), er);
                check("R4 sweep rem",  int'(rem_o), x - er * er * er);
            end else begin
                checks++;
            end
        end

        finish_run();
    end
endmodule